// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical address by adding it to one of six 16-bit segment bases. Segments always start on a 16-byte boundary, so each segment register keeps only the upper bits of its base. The implied low hex digit is zero, and the base is the stored value shifted left by four. The caller supplies an access kind, and the block picks the segment that kind uses by default. A per-access override can force any of the six segments instead.

The block also holds the source and destination index registers used by string transfers. A step strobe moves both registers by the element size (1, 2 or 4). A direction flag decides whether they count up or down. Segment registers and both index registers are loaded through write ports. The address and segment outputs are combinational from the current register contents.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, all six segment registers and both index registers hold zero, so every access gives phys_addr equal to the offset.
- R2: A segment write with seg_wr_sel in 0..5 replaces that register at the next rising clock edge. Select codes 0..5 mean code, data, stack, extra, aux0 and aux1. A write with select 6 or 7 changes no register.
- R3: phys_addr equals (selected segment × 16 + offset) modulo 2^20, and follows the inputs in the same cycle.
- R4: With no override, acc_kind 0 (instruction fetch) selects the code segment, and seg_used shows 0.
- R5: With no override, acc_kind 1 (stack access) and acc_kind 3 (base-pointer-relative access) select the stack segment, and seg_used shows 2.
- R6: With no override, acc_kind 2 (general data) selects the data segment, and seg_used shows 1.
- R7: With ovr_en high and ovr_sel in 0..5, the segment named by ovr_sel is used. With ovr_sel 6 or 7, the override is ignored and the default segment applies.
- R8: When idx_wr_en is high, src_idx and dst_idx take idx_wr_src and idx_wr_dst at the next rising edge.
- R9: When str_step is high, idx_wr_en is low and dir_flag is 0, both index registers increase by the step. The step is 1, 2 or 4 for elem_size 0, 1 or 2, and 4 for elem_size 3.
- R10: With dir_flag 1 the same step is subtracted instead. Both index registers wrap modulo 2^16 in either direction.
- R11: When idx_wr_en and str_step are high in the same cycle, the load wins and no step is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 3 | Segment register to write (0..5) |
| seg_wr_data | input | 16 | Segment value to write |
| acc_kind | input | 2 | Access kind: 0 fetch, 1 stack, 2 data, 3 base-pointer relative |
| ovr_en | input | 1 | Segment override enable |
| ovr_sel | input | 3 | Segment forced by the override |
| offset | input | 16 | Offset within the segment |
| idx_wr_en | input | 1 | Index register load strobe |
| idx_wr_src | input | 16 | Source index load value |
| idx_wr_dst | input | 16 | Destination index load value |
| str_step | input | 1 | String step strobe |
| dir_flag | input | 1 | Step direction: 0 up, 1 down |
| elem_size | input | 2 | Element size code: 0 byte, 1 two bytes, 2 and 3 four bytes |
| phys_addr | output | 20 | Physical address |
| seg_used | output | 3 | Segment that formed phys_addr |
| src_idx | output | 16 | Source index register |
| dst_idx | output | 16 | Destination index register |

## Verification
phys_addr and seg_used are combinational, so they are due in the same cycle the access kind, override and offset are applied. Segment writes, index loads and string steps show up only after the next rising edge. The bench changes inputs 1 ns after a falling edge and compares every output at the following falling edge. Each comparison therefore sees exactly one rising edge's worth of register updates together with the inputs now present. The reference model updates its segment and index state on that same rising edge and computes the expected address from those values and the current inputs.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
   localparam int SEL_W = 3;

   typedef enum logic [1:0] {
      ACC_FETCH   = 2'd0,
      ACC_STACK   = 2'd1,
      ACC_DATA    = 2'd2,
      ACC_BASEPTR = 2'd3
   } acc_kind_e;

   localparam logic [SEL_W-1:0] SEG_CODE  = 3'd0;
   localparam logic [SEL_W-1:0] SEG_DATA  = 3'd1;
   localparam logic [SEL_W-1:0] SEG_STACK = 3'd2;
   localparam logic [SEL_W-1:0] SEG_EXTRA = 3'd3;
   localparam logic [SEL_W-1:0] SEG_AUX0  = 3'd4;
   localparam logic [SEL_W-1:0] SEG_AUX1  = 3'd5;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
   parameter int SEG_W = 16,
   parameter int NSEG  = 6,
   parameter int SEL_W = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [SEL_W-1:0]           wr_sel,
   input  logic [SEG_W-1:0]           wr_data,
   output logic [NSEG-1:0][SEG_W-1:0] seg_q
);
   initial begin
      if (NSEG > (1 << SEL_W)) $fatal(1, "seg_regfile: NSEG does not fit SEL_W");
   end

   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            seg_q[g] <= '0;
         else if (wr_en && (wr_sel == SEL_W'(g)))
            seg_q[g] <= wr_data;
      end
   end
endmodule

// File: rtl/seg_select.sv
module seg_select
   import seg_addr_pkg::*;
#(
   parameter int NSEG = 6
) (
   input  logic [1:0]       acc_kind,
   input  logic             ovr_en,
   input  logic [SEL_W-1:0] ovr_sel,
   output logic [SEL_W-1:0] sel
);
   logic [SEL_W-1:0] dflt;
   logic             ovr_ok;

   always_comb begin
      unique case (acc_kind_e'(acc_kind))
         ACC_FETCH:   dflt = SEG_CODE;
         ACC_STACK:   dflt = SEG_STACK;
         ACC_DATA:    dflt = SEG_DATA;
         ACC_BASEPTR: dflt = SEG_STACK;
         default:     dflt = SEG_DATA;
      endcase
   end

   assign ovr_ok = ovr_en && (int'(ovr_sel) < NSEG);
   assign sel    = ovr_ok ? ovr_sel : dflt;
endmodule

// File: rtl/addr_adder.sv
module addr_adder #(
   parameter int SEG_W = 16,
   parameter int OFF_W = 16,
   parameter int SHIFT = 4,
   localparam int PA_W = SEG_W + SHIFT
) (
   input  logic [SEG_W-1:0] seg,
   input  logic [OFF_W-1:0] off,
   output logic [PA_W-1:0]  pa
);
   initial begin
      if (OFF_W > PA_W) $fatal(1, "addr_adder: offset wider than address");
   end

   logic [PA_W-1:0] base;

   if (SHIFT == 0) begin : g_noshift
      assign base = seg;
   end else begin : g_shift
      assign base = {seg, {SHIFT{1'b0}}};
   end

   assign pa = base + PA_W'(off);
endmodule

// File: rtl/index_stepper.sv
module index_stepper #(
   parameter int IDX_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic [IDX_W-1:0] ld_src,
   input  logic [IDX_W-1:0] ld_dst,
   input  logic             step,
   input  logic             dir,
   input  logic [1:0]       size,
   output logic [IDX_W-1:0] src_q,
   output logic [IDX_W-1:0] dst_q
);
   initial begin
      if (IDX_W < 3) $fatal(1, "index_stepper: IDX_W too small for a step of 4");
   end

   logic [IDX_W-1:0] delta;
   logic [IDX_W-1:0] src_n, dst_n;

   always_comb begin
      unique case (size)
         2'd0:    delta = IDX_W'(1);
         2'd1:    delta = IDX_W'(2);
         default: delta = IDX_W'(4);
      endcase
      src_n = dir ? (src_q - delta) : (src_q + delta);
      dst_n = dir ? (dst_q - delta) : (dst_q + delta);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= '0;
         dst_q <= '0;
      end else if (ld_en) begin
         src_q <= ld_src;
         dst_q <= ld_dst;
      end else if (step) begin
         src_q <= src_n;
         dst_q <= dst_n;
      end
   end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import seg_addr_pkg::*;
#(
   parameter int SEG_W = 16,
   parameter int OFF_W = 16,
   parameter int IDX_W = 16,
   parameter int SHIFT = 4,
   parameter int NSEG  = 6,
   localparam int PA_W = SEG_W + SHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seg_wr_en,
   input  logic [2:0]       seg_wr_sel,
   input  logic [SEG_W-1:0] seg_wr_data,
   input  logic [1:0]       acc_kind,
   input  logic             ovr_en,
   input  logic [2:0]       ovr_sel,
   input  logic [OFF_W-1:0] offset,
   input  logic             idx_wr_en,
   input  logic [IDX_W-1:0] idx_wr_src,
   input  logic [IDX_W-1:0] idx_wr_dst,
   input  logic             str_step,
   input  logic             dir_flag,
   input  logic [1:0]       elem_size,
   output logic [PA_W-1:0]  phys_addr,
   output logic [2:0]       seg_used,
   output logic [IDX_W-1:0] src_idx,
   output logic [IDX_W-1:0] dst_idx
);
   logic [NSEG-1:0][SEG_W-1:0] seg_q;
   logic [SEL_W-1:0]           sel;
   logic [SEG_W-1:0]           seg_val;

   seg_regfile #(.SEG_W(SEG_W), .NSEG(NSEG), .SEL_W(SEL_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (seg_wr_en),
      .wr_sel  (seg_wr_sel),
      .wr_data (seg_wr_data),
      .seg_q   (seg_q)
   );

   seg_select #(.NSEG(NSEG)) u_sel (
      .acc_kind (acc_kind),
      .ovr_en   (ovr_en),
      .ovr_sel  (ovr_sel),
      .sel      (sel)
   );

   always_comb begin
      seg_val = '0;
      for (int i = 0; i < NSEG; i++)
         if (sel == SEL_W'(i)) seg_val = seg_q[i];
   end

   addr_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_add (
      .seg (seg_val),
      .off (offset),
      .pa  (phys_addr)
   );

   index_stepper #(.IDX_W(IDX_W)) u_idx (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_en  (idx_wr_en),
      .ld_src (idx_wr_src),
      .ld_dst (idx_wr_dst),
      .step   (str_step),
      .dir    (dir_flag),
      .size   (elem_size),
      .src_q  (src_idx),
      .dst_q  (dst_idx)
   );

   assign seg_used = sel;
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
   parameter int SEG_W = 16,
   parameter int IDX_W = 16,
   parameter int NSEG  = 6
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       seg_wr_en,
   input logic [2:0]                 seg_wr_sel,
   input logic [SEG_W-1:0]           seg_wr_data,
   input logic [1:0]                 acc_kind,
   input logic                       ovr_en,
   input logic [2:0]                 ovr_sel,
   input logic                       idx_wr_en,
   input logic [IDX_W-1:0]           idx_wr_src,
   input logic                       str_step,
   input logic                       dir_flag,
   input logic [1:0]                 elem_size,
   input logic [2:0]                 seg_used,
   input logic [IDX_W-1:0]           src_idx,
   input logic [NSEG-1:0][SEG_W-1:0] seg_q
);
   for (genvar g = 0; g < NSEG; g++) begin : g_wr
      // R2
      seg_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (seg_wr_en && seg_wr_sel == 3'(g)) |=> (seg_q[g] == $past(seg_wr_data)));
   end

   // R4
   fetch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_en && acc_kind == 2'd0) |-> (seg_used == 3'd0));

   // R5
   stack_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_en && acc_kind[0]) |-> (seg_used == 3'd2));

   // R6
   data_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_en && acc_kind == 2'd2) |-> (seg_used == 3'd1));

   // R7
   override_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_en && int'(ovr_sel) < NSEG) |-> (seg_used == ovr_sel));

   // R8
   idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_wr_en |=> (src_idx == $past(idx_wr_src)));

   // R9
   step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (str_step && !idx_wr_en && !dir_flag && elem_size == 2'd0)
      |=> (src_idx == $past(src_idx) + IDX_W'(1)));

   // R10
   step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (str_step && !idx_wr_en && dir_flag && elem_size == 2'd2)
      |=> (src_idx == $past(src_idx) - IDX_W'(4)));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.SEG_W(SEG_W), .IDX_W(IDX_W), .NSEG(NSEG)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .seg_wr_en   (seg_wr_en),
   .seg_wr_sel  (seg_wr_sel),
   .seg_wr_data (seg_wr_data),
   .acc_kind    (acc_kind),
   .ovr_en      (ovr_en),
   .ovr_sel     (ovr_sel),
   .idx_wr_en   (idx_wr_en),
   .idx_wr_src  (idx_wr_src),
   .str_step    (str_step),
   .dir_flag    (dir_flag),
   .elem_size   (elem_size),
   .seg_used    (seg_used),
   .src_idx     (src_idx),
   .seg_q       (seg_q)
);

// File: tb/seg_addr_gen_tb.sv
`timescale 1ns/1ps
module seg_addr_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        seg_wr_en = 1'b0;
   logic [2:0]  seg_wr_sel = '0;
   logic [15:0] seg_wr_data = '0;
   logic [1:0]  acc_kind = '0;
   logic        ovr_en = 1'b0;
   logic [2:0]  ovr_sel = '0;
   logic [15:0] offset = '0;
   logic        idx_wr_en = 1'b0;
   logic [15:0] idx_wr_src = '0;
   logic [15:0] idx_wr_dst = '0;
   logic        str_step = 1'b0;
   logic        dir_flag = 1'b0;
   logic [1:0]  elem_size = '0;
   logic [19:0] phys_addr;
   logic [2:0]  seg_used;
   logic [15:0] src_idx;
   logic [15:0] dst_idx;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   seg_addr_gen u_dut (
      .clk(clk), .rst_n(rst_n),
      .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
      .acc_kind(acc_kind), .ovr_en(ovr_en), .ovr_sel(ovr_sel), .offset(offset),
      .idx_wr_en(idx_wr_en), .idx_wr_src(idx_wr_src), .idx_wr_dst(idx_wr_dst),
      .str_step(str_step), .dir_flag(dir_flag), .elem_size(elem_size),
      .phys_addr(phys_addr), .seg_used(seg_used), .src_idx(src_idx), .dst_idx(dst_idx)
   );

   // Reference state
   int    seg_m [6];
   int    src_m, dst_m;
   string idx_tag = "R1";
   bit    in_reset = 1'b1;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 6; i++) seg_m[i] <= 0;
         src_m <= 0; dst_m <= 0; idx_tag <= "R1";
      end else begin
         int st;
         st = (elem_size == 2'd0) ? 1 : (elem_size == 2'd1) ? 2 : 4;
         // R2: selects 6 and 7 write nothing
         if (seg_wr_en && seg_wr_sel < 3'd6) seg_m[seg_wr_sel] <= int'(seg_wr_data);
         if (idx_wr_en) begin
            src_m <= int'(idx_wr_src); dst_m <= int'(idx_wr_dst);
            idx_tag <= str_step ? "R11" : "R8";
         end else if (str_step) begin
            src_m <= dir_flag ? ((src_m - st) & 16'hFFFF) : ((src_m + st) & 16'hFFFF);
            dst_m <= dir_flag ? ((dst_m - st) & 16'hFFFF) : ((dst_m + st) & 16'hFFFF);
            idx_tag <= dir_flag ? "R10" : "R9";
         end
      end
   end

   function automatic int exp_sel();
      if (ovr_en && ovr_sel < 3'd6) return int'(ovr_sel);
      case (acc_kind)
         2'd0:    return 0;
         2'd2:    return 1;
         default: return 2;
      endcase
   endfunction

   task automatic check(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         int s, pa;
         string stag, ptag;
         s = exp_sel();
         pa = ((seg_m[s] << 4) + int'(offset)) & 20'hFFFFF;
         if (in_reset) begin
            stag = "R1"; ptag = "R1";
         end else begin
            ptag = "R3";
            if (ovr_en) stag = "R7";
            else if (acc_kind == 2'd0) stag = "R4";
            else if (acc_kind == 2'd2) stag = "R6";
            else stag = "R5";
         end
         check(seg_used == 3'(s), stag, "seg_used", int'(seg_used), s);
         check(phys_addr == 20'(pa), ptag, "phys_addr", int'(phys_addr), pa);
         check(src_idx == 16'(src_m), in_reset ? "R1" : idx_tag, "src_idx", int'(src_idx), src_m);
         check(dst_idx == 16'(dst_m), in_reset ? "R1" : idx_tag, "dst_idx", int'(dst_idx), dst_m);
      end
   end

   task automatic nxt();
      @(negedge clk); #1;
   endtask

   task automatic idle();
      seg_wr_en = 0; idx_wr_en = 0; str_step = 0; ovr_en = 0;
   endtask

   initial begin
      #300000;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset values observed with various kinds and offsets
      for (int i = 0; i < 4; i++) begin
         nxt(); acc_kind = 2'(i); offset = 16'h1234 + 16'(i);
      end
      nxt(); rst_n = 1'b1;
      nxt(); in_reset = 1'b0;
      // R2: load every segment with a distinct value, then try selects 6 and 7
      for (int i = 0; i < 8; i++) begin
         nxt(); seg_wr_en = 1; seg_wr_sel = 3'(i); seg_wr_data = 16'h1000 * 16'(i + 1) + 16'h0AB;
      end
      nxt(); idle();
      // R7: read each segment through the override, including codes 6 and 7
      for (int i = 0; i < 8; i++) begin
         nxt(); ovr_en = 1; ovr_sel = 3'(i); acc_kind = 2'(i % 4); offset = 16'h0F0F;
      end
      // R3: address wrap with maximum base and offset
      nxt(); ovr_en = 0; seg_wr_en = 1; seg_wr_sel = 3'd1; seg_wr_data = 16'hFFFF;
      nxt(); seg_wr_en = 0; acc_kind = 2'd2; offset = 16'hFFFF;
      // R4, R5, R6: default segments
      for (int i = 0; i < 4; i++) begin
         nxt(); acc_kind = 2'(i); offset = 16'h0040 * 16'(i);
      end
      // R8, R9, R10, R11: index wrap in both directions, and load against step
      nxt(); idx_wr_en = 1; idx_wr_src = 16'hFFFF; idx_wr_dst = 16'hFFFE;
      nxt(); idx_wr_en = 0; str_step = 1; dir_flag = 0; elem_size = 2'd0;
      nxt(); elem_size = 2'd2;
      nxt(); dir_flag = 1; elem_size = 2'd3;
      nxt(); elem_size = 2'd1;
      nxt(); idx_wr_en = 1; idx_wr_src = 16'h0100; idx_wr_dst = 16'h0200;
      nxt(); idle();
      // Random traffic
      for (int i = 0; i < 3000; i++) begin
         nxt();
         seg_wr_en   = ($urandom % 4) == 0;
         seg_wr_sel  = 3'($urandom);
         seg_wr_data = 16'($urandom);
         acc_kind    = 2'($urandom);
         ovr_en      = ($urandom % 3) == 0;
         ovr_sel     = 3'($urandom);
         offset      = 16'($urandom);
         idx_wr_en   = ($urandom % 6) == 0;
         idx_wr_src  = 16'($urandom);
         idx_wr_dst  = 16'($urandom);
         str_step    = ($urandom % 2) == 0;
         dir_flag    = 1'($urandom);
         elem_size   = 2'($urandom);
      end
      nxt(); idle();
      nxt();
      @(posedge clk); done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule